// File: doc/BRIEF.md
# Vector Shift and Rotate Unit

This block is a registered 128-bit SIMD shifter. It splits operand A into lanes of 8, 16 or 32 bits. It applies a logical left shift, a logical right shift, an arithmetic right shift or a left rotate to every lane. The count for each lane is taken from the lane in the same position in operand B.

It also moves the whole register at once:
- by a bit count from 0 to 7, in either direction;
- by a byte count from 0 to 15, in either direction;
- as a byte shift across the pair A:B, by an immediate count.

The caller presents the operands, the immediate and an opcode with a valid strobe. The result is registered, and it comes out one cycle later together with its own valid flag. The opcode arrives already decoded into the 5-bit form below.

Top module: `vsh_unit`

## Requirements
- R1: While reset is held, and after it until the first valid operation, outValid is 0 and result is all zeros.
- R2: The opcode bits [4:2] select the lane operation: 000 logical left, 001 logical right, 010 arithmetic right, 011 rotate left. Bits [1:0] select the lane width: 00 for 8 bits, 01 for 16 bits, 10 for 32 bits. Lane k occupies result bits [k*W+W-1 : k*W]. Its count is the low 3, 4 or 5 bits of the same lane of opB, and all higher count bits are ignored.
- R3: Logical lane shifts fill the vacated positions with zeros, and no bit crosses from one lane into another.
- R4: Arithmetic right lane shifts fill the vacated positions with copies of the lane's top bit.
- R5: Rotate left feeds each bit that leaves the top of a lane back into its bottom. A count of zero returns the lane unchanged.
- R6: Opcode 10000 shifts all 128 bits of A left, and opcode 10001 shifts them right. The count is opB[2:0], and bits cross every internal boundary, including the one between the two 64-bit halves.
- R7: Opcode 10010 shifts A left by whole bytes, and opcode 10011 shifts it right by whole bytes. The count is opB[6:3], in the range 0 to 15. Byte 0 is bits [127:120]. Vacated bytes are zero.
- R8: Opcode 10100 uses the 4-bit immediate sh. It returns bytes sh to 15 of A, followed by bytes 0 to sh-1 of B. Byte 0 is the most significant byte of each operand.
- R9: result and outValid update one clock after inValid is sampled high. When inValid is low, outValid is 0 on the next cycle and result holds its value. Back-to-back valid inputs give back-to-back results.
- R10: Opcodes not listed above produce an all-zero result. This covers lane kinds with width code 11, and codes 10101 to 11111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operands and opcode are valid this cycle |
| opcode | input | 5 | Decoded operation code (R2, R6 to R8) |
| opA | input | 128 | Data operand |
| opB | input | 128 | Count operand, or second data operand for the pair shift |
| shImm | input | 4 | Byte count for the pair shift |
| outValid | output | 1 | result holds a new value |
| result | output | 128 | Registered result |

## Verification
The bench builds the unit with its default 128-bit width. At this width the byte count field is opB[6:3], the immediate is 4 bits wide, and there are sixteen byte lanes, eight halfword lanes and four word lanes. That makes it possible to check counts up to 15 bytes and bit shifts across the 64-bit midpoint. The directed cases put out-of-range count bits in each lane and negative lanes under arithmetic shift. They also cover zero and full-range byte counts, unused opcodes, and consecutive valid cycles.

// File: rtl/vsh_pkg.sv
package vsh_pkg;

  // Lane operation kinds, carried in opcode[4:2].
  localparam logic [2:0] KIND_SLL = 3'd0;
  localparam logic [2:0] KIND_SRL = 3'd1;
  localparam logic [2:0] KIND_SRA = 3'd2;
  localparam logic [2:0] KIND_ROL = 3'd3;
  localparam logic [2:0] KIND_WHOLE = 3'd4;
  localparam logic [2:0] KIND_PAIR = 3'd5;

  // Lane width codes, carried in opcode[1:0].
  localparam logic [1:0] SIZE_B = 2'd0;
  localparam logic [1:0] SIZE_H = 2'd1;
  localparam logic [1:0] SIZE_W = 2'd2;

  // Full opcodes of the whole-register operations.
  localparam logic [4:0] OP_BITL = 5'b10000;
  localparam logic [4:0] OP_BITR = 5'b10001;
  localparam logic [4:0] OP_BYTL = 5'b10010;
  localparam logic [4:0] OP_BYTR = 5'b10011;
  localparam logic [4:0] OP_PAIR = 5'b10100;

  typedef enum logic [2:0] {
    WH_BITL = 3'd0,
    WH_BITR = 3'd1,
    WH_BYTL = 3'd2,
    WH_BYTR = 3'd3,
    WH_PAIR = 3'd4
  } whole_sel_e;

  // Strobes sent from the control to the datapath.
  typedef struct packed {
    logic       capture;
    logic       laneSel;
    logic [1:0] laneKind;
    logic [1:0] laneSize;
    whole_sel_e wholeSel;
    logic       zeroRes;
  } strobe_t;

endpackage

// File: rtl/vsh_ctrl.sv
module vsh_ctrl
  import vsh_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [4:0] opcode,
  output strobe_t    strobe,
  output logic       outValid
);

  logic [2:0] kind;
  logic [1:0] size;

  assign kind = opcode[4:2];
  assign size = opcode[1:0];

  always_comb begin
    strobe          = '0;
    strobe.capture  = inValid;
    strobe.laneKind = kind[1:0];
    strobe.laneSize = size;
    strobe.wholeSel = WH_BITL;
    if (kind <= KIND_ROL && size != 2'd3) begin
      strobe.laneSel = 1'b1;
    end else if (kind == KIND_WHOLE) begin
      strobe.wholeSel = whole_sel_e'({1'b0, size});
    end else if (opcode == OP_PAIR) begin
      strobe.wholeSel = WH_PAIR;
    end else begin
      strobe.zeroRes = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

endmodule

// File: rtl/vsh_lane_bank.sv
module vsh_lane_bank #(
  parameter int VEC_W  = 128,
  parameter int LANE_W = 8
) (
  input  logic [VEC_W-1:0] opA,
  input  logic [VEC_W-1:0] opB,
  input  logic [1:0]       laneKind,
  output logic [VEC_W-1:0] bankRes
);

  localparam int NLANES = VEC_W / LANE_W;
  localparam int CNT_W  = $clog2(LANE_W);

  for (genvar l = 0; l < NLANES; l++) begin : g_lane
    logic [LANE_W-1:0]   aLane;
    logic [CNT_W-1:0]    cnt;
    logic [2*LANE_W-1:0] rotCat;
    logic [LANE_W-1:0]   sll, srl, sra, rol;

    assign aLane  = opA[l*LANE_W +: LANE_W];
    assign cnt    = opB[l*LANE_W +: CNT_W];
    assign sll    = aLane << cnt;
    assign srl    = aLane >> cnt;
    assign sra    = LANE_W'($signed(aLane) >>> cnt);
    assign rotCat = {aLane, aLane} << cnt;
    assign rol    = rotCat[2*LANE_W-1:LANE_W];

    always_comb begin
      unique case (laneKind)
        2'd0:    bankRes[l*LANE_W +: LANE_W] = sll;
        2'd1:    bankRes[l*LANE_W +: LANE_W] = srl;
        2'd2:    bankRes[l*LANE_W +: LANE_W] = sra;
        default: bankRes[l*LANE_W +: LANE_W] = rol;
      endcase
    end
  end

endmodule

// File: rtl/vsh_whole.sv
module vsh_whole
  import vsh_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic [VEC_W-1:0]                opA,
  input  logic [VEC_W-1:0]                opB,
  input  logic [$clog2(VEC_W/8)-1:0]      shImm,
  input  whole_sel_e                      wholeSel,
  output logic [VEC_W-1:0]                wholeRes
);

  localparam int BIDX_W = $clog2(VEC_W / 8);
  localparam int BAMT_W = BIDX_W + 3;

  logic [2:0]          bitCnt;
  logic [BIDX_W-1:0]   byteCnt;
  logic [BAMT_W-1:0]   byteAmt;
  logic [BAMT_W-1:0]   immAmt;
  logic [2*VEC_W-1:0]  pairCat;

  assign bitCnt  = opB[2:0];
  assign byteCnt = opB[3 +: BIDX_W];
  assign byteAmt = {byteCnt, 3'b000};
  assign immAmt  = {shImm, 3'b000};
  assign pairCat = {opA, opB} << immAmt;

  always_comb begin
    unique case (wholeSel)
      WH_BITL: wholeRes = opA << bitCnt;
      WH_BITR: wholeRes = opA >> bitCnt;
      WH_BYTL: wholeRes = opA << byteAmt;
      WH_BYTR: wholeRes = opA >> byteAmt;
      default: wholeRes = pairCat[2*VEC_W-1:VEC_W];
    endcase
  end

endmodule

// File: rtl/vsh_datapath.sv
module vsh_datapath
  import vsh_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  strobe_t                     strobe,
  input  logic [VEC_W-1:0]            opA,
  input  logic [VEC_W-1:0]            opB,
  input  logic [$clog2(VEC_W/8)-1:0]  shImm,
  output logic [VEC_W-1:0]            result
);

  localparam int NSIZES = 3;

  logic [VEC_W-1:0] laneRes [NSIZES];
  logic [VEC_W-1:0] wholeRes;
  logic [VEC_W-1:0] nextRes;

  for (genvar s = 0; s < NSIZES; s++) begin : g_bank
    vsh_lane_bank #(
      .VEC_W (VEC_W),
      .LANE_W(8 << s)
    ) bank_i (
      .opA     (opA),
      .opB     (opB),
      .laneKind(strobe.laneKind),
      .bankRes (laneRes[s])
    );
  end

  vsh_whole #(.VEC_W(VEC_W)) whole_i (
    .opA     (opA),
    .opB     (opB),
    .shImm   (shImm),
    .wholeSel(strobe.wholeSel),
    .wholeRes(wholeRes)
  );

  always_comb begin
    if (strobe.zeroRes) begin
      nextRes = '0;
    end else if (strobe.laneSel) begin
      unique case (strobe.laneSize)
        SIZE_B:  nextRes = laneRes[0];
        SIZE_H:  nextRes = laneRes[1];
        default: nextRes = laneRes[2];
      endcase
    end else begin
      nextRes = wholeRes;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               result <= '0;
    else if (strobe.capture) result <= nextRes;
  end

endmodule

// File: rtl/vsh_unit.sv
module vsh_unit
  import vsh_pkg::*;
#(
  parameter  int VEC_W = 128,
  localparam int IMM_W = $clog2(VEC_W / 8)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [4:0]       opcode,
  input  logic [VEC_W-1:0] opA,
  input  logic [VEC_W-1:0] opB,
  input  logic [IMM_W-1:0] shImm,
  output logic             outValid,
  output logic [VEC_W-1:0] result
);

  strobe_t strobe;

  vsh_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .opcode  (opcode),
    .strobe  (strobe),
    .outValid(outValid)
  );

  vsh_datapath #(.VEC_W(VEC_W)) dp_i (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .opA   (opA),
    .opB   (opB),
    .shImm (shImm),
    .result(result)
  );

endmodule

// File: rtl/vsh_unit_chk.sv
module vsh_unit_chk
  import vsh_pkg::*;
#(
  parameter int VEC_W = 128,
  parameter int IMM_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic [4:0]       opcode,
  input logic [VEC_W-1:0] opA,
  input logic [VEC_W-1:0] opB,
  input logic [IMM_W-1:0] shImm,
  input logic             outValid,
  input logic [VEC_W-1:0] result
);

  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid == $past(inValid));

  // R9
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(inValid) |-> $stable(result));

  // R6
  bit_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(inValid && opcode == OP_BITL && opB[2:0] == 3'd0) |-> result == $past(opA));

  // R8
  pair_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(inValid && opcode == OP_PAIR && shImm == '0) |-> result == $past(opA));

  // R4
  sra_sign_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(inValid && opcode[4:2] == KIND_SRA && opcode[1:0] != 2'd3)
      |-> result[VEC_W-1] == $past(opA[VEC_W-1]));

  // R10
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(inValid && opcode > OP_PAIR) |-> result == '0);

endmodule

bind vsh_unit vsh_unit_chk #(.VEC_W(VEC_W), .IMM_W(IMM_W)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .opcode  (opcode),
  .opA     (opA),
  .opB     (opB),
  .shImm   (shImm),
  .outValid(outValid),
  .result  (result)
);

// File: tb/vsh_unit_tb_top.sv
module vsh_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int VW = 128;
  localparam int NB = VW / 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic [4:0]    opcode = '0;
  logic [VW-1:0] opA = '0;
  logic [VW-1:0] opB = '0;
  logic [3:0]    shImm = '0;
  logic          outValid;
  logic [VW-1:0] result;

  int nChecks = 0;
  int nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vsh_unit #(.VEC_W(VW)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opcode(opcode),
    .opA(opA), .opB(opB), .shImm(shImm), .outValid(outValid), .result(result)
  );

  task automatic check(input string req, input logic [VW-1:0] got, input logic [VW-1:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Bit-level lane model, written from the requirements.
  function automatic logic [VW-1:0] laneRef(input logic [4:0] op, input logic [VW-1:0] a,
                                            input logic [VW-1:0] b);
    logic [VW-1:0] r = '0;
    int w = 8 << op[1:0];
    int cw = 3 + op[1:0];
    for (int l = 0; l < VW / w; l++) begin
      int base = l * w;
      int c = 0;
      for (int j = 0; j < cw; j++) if (b[base + j]) c += (1 << j);
      for (int j = 0; j < w; j++) begin
        case (op[4:2])
          3'd0: r[base + j] = (j >= c) ? a[base + j - c] : 1'b0;
          3'd1: r[base + j] = (j + c < w) ? a[base + j + c] : 1'b0;
          3'd2: r[base + j] = (j + c < w) ? a[base + j + c] : a[base + w - 1];
          default: r[base + j] = a[base + ((j - c + w) % w)];
        endcase
      end
    end
    return r;
  endfunction

  function automatic logic [7:0] byteOf(input logic [VW-1:0] v, input int i);
    return v[VW - 1 - 8 * i -: 8];
  endfunction

  function automatic logic [VW-1:0] byteRef(input logic [VW-1:0] a, input int s, input bit left);
    logic [VW-1:0] r = '0;
    for (int i = 0; i < NB; i++) begin
      logic [7:0] bv = 8'h00;
      if (left && i + s < NB) bv = byteOf(a, i + s);
      if (!left && i - s >= 0) bv = byteOf(a, i - s);
      r[VW - 1 - 8 * i -: 8] = bv;
    end
    return r;
  endfunction

  function automatic logic [VW-1:0] pairRef(input logic [VW-1:0] a, input logic [VW-1:0] b, input int s);
    logic [VW-1:0] r = '0;
    for (int i = 0; i < NB; i++)
      r[VW - 1 - 8 * i -: 8] = (i + s < NB) ? byteOf(a, i + s) : byteOf(b, i + s - NB);
    return r;
  endfunction

  function automatic logic [VW-1:0] bitRef(input logic [VW-1:0] a, input int c, input bit left);
    logic [VW-1:0] r = '0;
    for (int i = 0; i < VW; i++) begin
      if (left) r[i] = (i >= c) ? a[i - c] : 1'b0;
      else      r[i] = (i + c < VW) ? a[i + c] : 1'b0;
    end
    return r;
  endfunction

  // Drive one valid operation, then sample after the capturing edge.
  task automatic issue(input logic [4:0] op, input logic [VW-1:0] a, input logic [VW-1:0] b,
                       input logic [3:0] imm);
    @(negedge clk);
    opcode = op; opA = a; opB = b; shImm = imm; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 outValid", {127'd0, outValid}, '0);
    check("R1 result", result, '0);
  endtask

  task automatic t_logical();
    logic [VW-1:0] a = 128'hF0E1_D2C3_B4A5_9687_7869_5A4B_3C2D_1E0F;
    logic [VW-1:0] b = 128'h0B0C_0D0E_0F08_0901_F2E3_D4C5_B6A7_9880;
    for (int s = 0; s < 3; s++) begin
      issue({3'd0, 2'(s)}, a, b, 4'd0);
      check("R2 R3 sll", result, laneRef({3'd0, 2'(s)}, a, b));
      issue({3'd1, 2'(s)}, a, b, 4'd0);
      check("R2 R3 srl", result, laneRef({3'd1, 2'(s)}, a, b));
    end
    issue(5'b00000, {NB{8'hFF}}, {NB{8'h0B}}, 4'd0);
    check("R2 byte count masked to 3", result, {NB{8'hF8}});
  endtask

  task automatic t_arith();
    logic [VW-1:0] a = 128'h8001_7FFE_C000_0123_FEDC_BA98_8000_0001;
    logic [VW-1:0] b = 128'h0F1F_0304_2507_0011_001F_0008_0021_0000;
    for (int s = 0; s < 3; s++) begin
      issue({3'd2, 2'(s)}, a, b, 4'd0);
      check("R4 sra", result, laneRef({3'd2, 2'(s)}, a, b));
    end
    issue(5'b01010, {4{32'h8000_0000}}, {4{32'h0000_003F}}, 4'd0);
    check("R4 word sign fill", result, {4{32'hFFFF_FFFF}});
  endtask

  task automatic t_rotate();
    logic [VW-1:0] a = 128'h8123_4567_89AB_CDEF_0F1E_2D3C_4B5A_6978;
    logic [VW-1:0] b = 128'h0001_0207_0010_0F00_1F20_0000_3F04_0509;
    for (int s = 0; s < 3; s++) begin
      issue({3'd3, 2'(s)}, a, b, 4'd0);
      check("R5 rol", result, laneRef({3'd3, 2'(s)}, a, b));
    end
    issue(5'b01110, a, {4{32'h0000_0020}}, 4'd0);
    check("R5 rol zero count", result, a);
  endtask

  task automatic t_bitshift();
    logic [VW-1:0] a = 128'h0123_4567_89AB_CDEF_F000_0000_0000_000F;
    for (int c = 0; c < 8; c += 3) begin
      issue(5'b10000, a, {NB{8'(c)}}, 4'd0);
      check("R6 bit left", result, bitRef(a, c, 1'b1));
      issue(5'b10001, a, {NB{8'(c)}}, 4'd0);
      check("R6 bit right", result, bitRef(a, c, 1'b0));
    end
  endtask

  task automatic t_byteshift();
    logic [VW-1:0] a = 128'h00112233_44556677_8899AABB_CCDDEEFF;
    int counts[3] = '{0, 5, 15};
    foreach (counts[k]) begin
      logic [VW-1:0] b = {120'hA5A5, 1'b1, 4'(counts[k]), 3'b111};
      issue(5'b10010, a, b, 4'd0);
      check("R7 byte left", result, byteRef(a, counts[k], 1'b1));
      issue(5'b10011, a, b, 4'd0);
      check("R7 byte right", result, byteRef(a, counts[k], 1'b0));
    end
  endtask

  task automatic t_pair();
    logic [VW-1:0] a = 128'h00112233_44556677_8899AABB_CCDDEEFF;
    logic [VW-1:0] b = 128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0;
    int imms[3] = '{0, 3, 15};
    foreach (imms[k]) begin
      issue(5'b10100, a, b, 4'(imms[k]));
      check("R8 pair shift", result, pairRef(a, b, imms[k]));
    end
    issue(5'b10100, a, b, 4'd3);
    check("R8 pair sh=3 literal", result, 128'h33445566_778899AA_BBCCDDEE_FF0F1E2D);
  endtask

  task automatic t_hold();
    logic [VW-1:0] held;
    issue(5'b00000, {NB{8'h01}}, {NB{8'h01}}, 4'd0);
    held = result;
    check("R9 outValid after valid", {127'd0, outValid}, 128'd1);
    @(negedge clk);
    opcode = 5'b10001; opA = '1; opB = '1; shImm = 4'hF;
    @(negedge clk);
    check("R9 hold while idle", result, held);
    check("R9 outValid low while idle", {127'd0, outValid}, '0);
  endtask

  task automatic t_stream();
    logic [VW-1:0] a = 128'hDEAD_BEEF_0123_4567_89AB_CDEF_FEDC_BA98;
    @(negedge clk);
    opcode = 5'b10010; opA = a; opB = 128'h8; inValid = 1'b1;
    @(negedge clk);
    check("R9 first of pair", result, byteRef(a, 1, 1'b1));
    opcode = 5'b10011; opB = 128'h10;
    @(negedge clk);
    inValid = 1'b0;
    check("R9 second of pair", result, byteRef(a, 2, 1'b0));
    check("R9 valid stays high", {127'd0, outValid}, 128'd1);
  endtask

  task automatic t_unused();
    logic [4:0] ops[4] = '{5'b00011, 5'b01111, 5'b10101, 5'b11111};
    foreach (ops[k]) begin
      issue(5'b10000, '1, '0, 4'd0);
      issue(ops[k], '1, 128'h5, 4'd2);
      check("R10 unused opcode zero", result, '0);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_logical();
    t_arith();
    t_rotate();
    t_bitshift();
    t_byteshift();
    t_pair();
    t_hold();
    t_stream();
    t_unused();
    finishRun();
  end

endmodule